// File: doc/BRIEF.md
# Vector Fail-First Compare Sequencer

This block steps through a vector compare one element per clock. For each element index from 0 up to the effective vector length, it compares the element against a scalar operand as signed numbers. It then emits a 4-bit condition field for that element on a write port. The effective length is the smaller of the requested length and the maximum length, and both are latched when a start pulse arrives.

With fail-first enabled, each freshly computed field is tested against one of its bits, and the test can be inverted. The first element whose test succeeds ends the loop and shortens the vector length. The shortened length can either count the element that hit or leave it out. When it leaves it out, the hit element's field write is dropped, so its field keeps its previous value. Each field write is held back by one step and committed only once its test outcome is known, so no backup copy of the field store is needed.

The element operand is fetched through an index output: `elem_data` must present element `elem_idx` in the same cycle. A one-cycle `done` pulse marks the end of the loop, and `vl_out` holds the resulting vector length.

Top module: `ffcmp_seq`

## Requirements
- R1: Each written field is a signed comparison of the element against `scalar`: 8 (bit 3) when the element is less, 4 (bit 2) when greater, 2 (bit 1) when equal. Bit 0 is always 0.
- R2: For N = min(`vl_in`, `maxvl_in`) with no truncation, the fields are written to addresses 0..N-1 in increasing order, one per clock. The write for index i appears on the cycle after `elem_idx` equals i.
- R3: `done` is high for exactly one cycle per accepted start. In that cycle `vl_out` holds the final length, which is N when no truncation occurs. After reset, `done`, `cr_we` and `vl_out` are 0.
- R4: The fail-first test bit is chosen by `bit_sel`: 0 selects bit 3 (LT), 1 selects bit 2 (GT), 2 selects bit 1 (EQ), and 3 selects bit 0 (always 0). The test result is inverted when `ff_inv` is 1.
- R5: When `tgt5` is 1, the test uses bit 1 (EQ) whatever `bit_sel` holds.
- R6: On a hit at index s with `ff_vli` = 1, the field for s is written and `vl_out` becomes s+1.
- R7: On a hit at index s with `ff_vli` = 0, no write is made for s and `vl_out` becomes s.
- R8: After a hit, no element with a larger index is written.
- R9: When `ff_en` or `rc_en` is 0, no truncation occurs and all N fields are written.
- R10: When N is 0, `done` pulses on the cycle after the start, no write is made and `vl_out` is 0.
- R11: A start pulse while the loop is running is ignored. Operands and controls are latched at the accepted start, and `scalar` is held by the user until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| vl_in | input | VL_W | Requested vector length |
| maxvl_in | input | VL_W | Maximum vector length |
| ff_en | input | 1 | Fail-first enable |
| rc_en | input | 1 | Record/test enable |
| ff_inv | input | 1 | Invert the test bit |
| ff_vli | input | 1 | Shortened length includes the hit element |
| bit_sel | input | 2 | Test bit selector |
| tgt5 | input | 1 | Force test bit to EQ |
| scalar | input | DATA_W | Scalar compare operand |
| elem_data | input | DATA_W | Element value at `elem_idx` |
| elem_idx | output | VL_W | Index of element being compared |
| cr_we | output | 1 | Field write enable |
| cr_waddr | output | VL_W | Field write address |
| cr_wdata | output | 4 | Field value |
| vl_out | output | VL_W | Resulting vector length |
| done | output | 1 | End-of-loop pulse |

## Verification
The three-element ramp against its middle value is tried with EQ and GT tests, both inclusive and exclusive. This separates a write that is kept from one that is rolled back, and an early hit from a late one. Always-hit patterns (inverted bit 0) and the forced-EQ flag are used to check that the selector and inversion pick the right bit. Disabled tests, a zero length and a length clamped by the maximum check the length logic apart from fail-first. Random runs with small signed values give frequent ties and negative operands, and they mix every control setting.

// File: rtl/ffcmp_pkg.sv
package ffcmp_pkg;
  localparam int FLD_W  = 4;
  localparam int BIT_LT = 3;
  localparam int BIT_GT = 2;
  localparam int BIT_EQ = 1;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    logic       ff_en;
    logic       rc_en;
    logic       inv;
    logic       vli;
    logic [1:0] sel;
    logic       tgt5;
  } ff_ctrl_t;
endpackage

// File: rtl/ffcmp_cmp.sv
module ffcmp_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          elem,
  input  logic [DATA_W-1:0]          scalar,
  output logic [ffcmp_pkg::FLD_W-1:0] field
);
  import ffcmp_pkg::*;

  logic signed [DATA_W-1:0] a_s, b_s;

  always_comb begin
    a_s   = elem;
    b_s   = scalar;
    field = '0;
    if (a_s < b_s)      field[BIT_LT] = 1'b1;
    else if (a_s > b_s) field[BIT_GT] = 1'b1;
    else                field[BIT_EQ] = 1'b1;
  end
endmodule

// File: rtl/ffcmp_bitsel.sv
module ffcmp_bitsel (
  input  logic [ffcmp_pkg::FLD_W-1:0] field,
  input  logic                        ff_en,
  input  logic                        rc_en,
  input  logic                        inv,
  input  logic [1:0]                  sel,
  input  logic                        tgt5,
  output logic                        hit
);
  logic [1:0] sel_eff;
  logic       tbit;

  always_comb begin
    sel_eff = tgt5 ? 2'd2 : sel;
    case (sel_eff)
      2'd0:    tbit = field[3];
      2'd1:    tbit = field[2];
      2'd2:    tbit = field[1];
      default: tbit = field[0];
    endcase
    hit = ff_en & rc_en & (tbit ^ inv);
  end
endmodule

// File: rtl/ffcmp_ctrl.sv
module ffcmp_ctrl #(
  parameter int VL_W = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [VL_W-1:0]               vl_in,
  input  logic [VL_W-1:0]               maxvl_in,
  input  ffcmp_pkg::ff_ctrl_t           ctrl_in,
  input  logic                          hit,
  input  logic [ffcmp_pkg::FLD_W-1:0]   field,
  output ffcmp_pkg::ff_ctrl_t           ctrl_q,
  output logic [VL_W-1:0]               step,
  output logic                          cr_we,
  output logic [VL_W-1:0]               cr_waddr,
  output logic [ffcmp_pkg::FLD_W-1:0]   cr_wdata,
  output logic [VL_W-1:0]               vl_out,
  output logic                          done
);
  import ffcmp_pkg::*;

  seq_state_e      state;
  logic [VL_W-1:0] lim;
  logic [VL_W-1:0] n_eff;
  logic [VL_W-1:0] vli_ext;
  logic            last;

  always_comb begin
    n_eff   = (vl_in < maxvl_in) ? vl_in : maxvl_in;
    vli_ext = {{(VL_W-1){1'b0}}, ctrl_q.vli};
    last    = (step == lim - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ctrl_q   <= '0;
      lim      <= '0;
      step     <= '0;
      cr_we    <= 1'b0;
      cr_waddr <= '0;
      cr_wdata <= '0;
      vl_out   <= '0;
      done     <= 1'b0;
    end else begin
      cr_we <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ctrl_q <= ctrl_in;
            lim    <= n_eff;
            vl_out <= n_eff;
            step   <= '0;
            if (n_eff == '0) done  <= 1'b1;
            else             state <= ST_RUN;
          end
        end
        default: begin
          if (!hit || ctrl_q.vli) begin
            cr_we    <= 1'b1;
            cr_waddr <= step;
            cr_wdata <= field;
          end
          if (hit) begin
            vl_out <= step + vli_ext;
            state  <= ST_IDLE;
            done   <= 1'b1;
          end else if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ffcmp_seq.sv
module ffcmp_seq #(
  parameter int VL_W   = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [VL_W-1:0]   maxvl_in,
  input  logic              ff_en,
  input  logic              rc_en,
  input  logic              ff_inv,
  input  logic              ff_vli,
  input  logic [1:0]        bit_sel,
  input  logic              tgt5,
  input  logic [DATA_W-1:0] scalar,
  input  logic [DATA_W-1:0] elem_data,
  output logic [VL_W-1:0]   elem_idx,
  output logic              cr_we,
  output logic [VL_W-1:0]   cr_waddr,
  output logic [3:0]        cr_wdata,
  output logic [VL_W-1:0]   vl_out,
  output logic              done
);
  import ffcmp_pkg::*;

  ff_ctrl_t         ctrl_in, ctrl_q;
  logic [FLD_W-1:0] field;
  logic             hit;

  always_comb begin
    ctrl_in.ff_en = ff_en;
    ctrl_in.rc_en = rc_en;
    ctrl_in.inv   = ff_inv;
    ctrl_in.vli   = ff_vli;
    ctrl_in.sel   = bit_sel;
    ctrl_in.tgt5  = tgt5;
  end

  ffcmp_cmp #(.DATA_W(DATA_W)) u_cmp (
    .elem   (elem_data),
    .scalar (scalar),
    .field  (field)
  );

  ffcmp_bitsel u_sel (
    .field (field),
    .ff_en (ctrl_q.ff_en),
    .rc_en (ctrl_q.rc_en),
    .inv   (ctrl_q.inv),
    .sel   (ctrl_q.sel),
    .tgt5  (ctrl_q.tgt5),
    .hit   (hit)
  );

  ffcmp_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .vl_in    (vl_in),
    .maxvl_in (maxvl_in),
    .ctrl_in  (ctrl_in),
    .hit      (hit),
    .field    (field),
    .ctrl_q   (ctrl_q),
    .step     (elem_idx),
    .cr_we    (cr_we),
    .cr_waddr (cr_waddr),
    .cr_wdata (cr_wdata),
    .vl_out   (vl_out),
    .done     (done)
  );
endmodule

// File: rtl/ffcmp_seq_chk.sv
module ffcmp_seq_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [VL_W-1:0] elem_idx,
  input logic            cr_we,
  input logic [VL_W-1:0] cr_waddr,
  input logic [3:0]      cr_wdata,
  input logic [VL_W-1:0] vl_out,
  input logic            done
);
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_field_valid: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr_wdata) == 1 && !cr_wdata[0]));

  a_r2_addr_from_idx: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> cr_waddr == $past(elem_idx));

  a_r2_addr_ascending: assert property (@(posedge clk) disable iff (rst)
    (cr_we && $past(cr_we)) |-> cr_waddr == $past(cr_waddr) + 1'b1);

  a_r8_write_below_vl: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> cr_waddr < vl_out);
endmodule

bind ffcmp_seq ffcmp_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .elem_idx (elem_idx),
  .cr_we    (cr_we),
  .cr_waddr (cr_waddr),
  .cr_wdata (cr_wdata),
  .vl_out   (vl_out),
  .done     (done)
);

// File: tb/tb_ffcmp_seq.sv
module tb_ffcmp_seq;
  localparam int VL_W   = 7;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1 << VL_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [VL_W-1:0]   vl_in, maxvl_in;
  logic              ff_en, rc_en, ff_inv, ff_vli, tgt5;
  logic [1:0]        bit_sel;
  logic [DATA_W-1:0] scalar, elem_data;
  logic [VL_W-1:0]   elem_idx, cr_waddr, vl_out;
  logic              cr_we, done;
  logic [3:0]        cr_wdata;

  logic signed [DATA_W-1:0] elems [DEPTH];
  logic [3:0] crm    [DEPTH];
  logic [3:0] exp_cr [DEPTH];
  int exp_vl, exp_nw;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign elem_data = elems[elem_idx];

  ffcmp_seq #(.VL_W(VL_W), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [3:0] fld(input logic signed [DATA_W-1:0] a,
                                     input logic signed [DATA_W-1:0] b);
    if (a < b) return 4'd8;
    if (a > b) return 4'd4;
    return 4'd2;
  endfunction

  function automatic void model(input int nv, input int nm, input bit fe, input bit re,
                                input bit inv, input bit vli, input int sel, input bit t5,
                                input logic signed [DATA_W-1:0] sc);
    int n = (nv < nm) ? nv : nm;
    int s = t5 ? 2 : sel;
    for (int i = 0; i < DEPTH; i++) exp_cr[i] = 4'h1;
    exp_vl = n;
    exp_nw = 0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] f = fld(elems[i], sc);
      bit h = fe && re && (f[3 - s] ^ inv);
      if (!h || vli) begin
        exp_cr[i] = f;
        exp_nw++;
      end
      if (h) begin
        exp_vl = i + (vli ? 1 : 0);
        break;
      end
    end
  endfunction

  task automatic run_op(input int nv, input int nm, input bit fe, input bit re,
                        input bit inv, input bit vli, input int sel, input bit t5,
                        input int sc, input bit bogus, input string tag);
    int cyc = 0, nw = 0, lastaddr = -1;
    bit order_ok = 1;
    for (int i = 0; i < DEPTH; i++) crm[i] = 4'h1;
    model(nv, nm, fe, re, inv, vli, sel, t5, sc);
    @(negedge clk);
    vl_in = nv[VL_W-1:0]; maxvl_in = nm[VL_W-1:0];
    ff_en = fe; rc_en = re; ff_inv = inv; ff_vli = vli;
    bit_sel = sel[1:0]; tgt5 = t5; scalar = sc; start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (bogus && cyc == 2) begin
        start = 1'b1;
        vl_in = 7'd3;
        ff_en = 1'b1;
      end
      if (cr_we) begin
        if (int'(cr_waddr) != lastaddr + 1) order_ok = 0;
        lastaddr = int'(cr_waddr);
        crm[cr_waddr] = cr_wdata;
        nw++;
      end
      if (done) break;
      cyc++;
      if (cyc > 300) begin
        check(0, {tag, " done timeout"}, cyc, 0);
        return;
      end
    end
    check(int'(vl_out) == exp_vl, {tag, " R3 R6 R7 vl_out"}, int'(vl_out), exp_vl);
    check(nw == exp_nw, {tag, " R2 R8 write count"}, nw, exp_nw);
    check(order_ok, {tag, " R2 ascending addresses"}, lastaddr, exp_nw - 1);
    for (int i = 0; i < DEPTH; i++)
      if (crm[i] != exp_cr[i]) begin
        check(0, {tag, " R1 R7 field"}, int'(crm[i]), int'(exp_cr[i]));
        break;
      end
    n_chk++;
    @(negedge clk);
    start = 1'b0;
    check(!done, {tag, " R3 done one cycle"}, int'(done), 0);
    check(!cr_we, {tag, " R8 no write after done"}, int'(cr_we), 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(1234);
    rst = 1'b1; start = 1'b0; vl_in = '0; maxvl_in = '0;
    ff_en = 0; rc_en = 0; ff_inv = 0; ff_vli = 0; bit_sel = 0; tgt5 = 0; scalar = '0;
    for (int i = 0; i < DEPTH; i++) elems[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!done && !cr_we && vl_out == '0, "R3 reset state", int'(vl_out), 0);

    elems[0] = 1; elems[1] = 2; elems[2] = 3;
    run_op(3, 3, 1, 1, 0, 0, 2, 0, 2, 0, "R7 eq excl");        // vl 1, [8,-,-]
    run_op(3, 3, 1, 1, 0, 1, 2, 0, 2, 0, "R6 eq incl");        // vl 2, [8,2,-]
    run_op(3, 3, 1, 1, 0, 0, 1, 0, 2, 0, "R7 R8 gt excl");     // vl 2, [8,2,-]
    run_op(3, 3, 1, 1, 0, 0, 0, 1, 2, 0, "R5 tgt5 forces eq"); // vl 1
    run_op(3, 3, 1, 1, 1, 0, 3, 0, 2, 0, "R4 inv bit0 excl");  // vl 0, no writes
    run_op(3, 3, 1, 1, 1, 1, 3, 0, 2, 0, "R4 inv bit0 incl");  // vl 1
    run_op(3, 3, 0, 1, 0, 0, 2, 0, 2, 0, "R9 ff off");
    run_op(3, 3, 1, 0, 0, 0, 2, 0, 2, 0, "R9 rc off");
    run_op(0, 5, 1, 1, 1, 1, 3, 0, 2, 0, "R10 zero vl");
    for (int i = 0; i < 12; i++) elems[i] = i - 6;
    run_op(10, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R2 maxvl clamp");
    run_op(10, 12, 0, 1, 0, 0, 2, 0, 0, 1, "R11 start while busy");
    run_op(12, 12, 0, 0, 0, 0, 0, 0, -3, 0, "R1 signed mix");

    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 24; i++) elems[i] = $signed($urandom_range(8)) - 4;
      run_op($urandom_range(20), $urandom_range(24), $urandom_range(1) == 0,
             $urandom_range(3) != 0, $urandom_range(1) == 0, $urandom_range(1) == 0,
             $urandom_range(3), $urandom_range(3) == 0, $signed($urandom_range(8)) - 4,
             0, "R4 R6 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule